// File: doc/BRIEF.md
# NAND Hamming ECC Engine

This engine watches the bytes that cross a NAND controller's data port and builds a single-error-correcting Hamming code over every 256-byte chunk. Each chunk yields three code bytes, so a 512-byte page yields two independent groups of three. A bit flip anywhere in a chunk can later be located by comparing the stored code with a freshly computed one. That comparison, the correction and the flash bus timing are handled elsewhere.

Software drives the engine through a two-bit mode field, which sits at bits 6:5 of the controller's mode register. The usual order is: clear, off, accumulate while the page moves, then off, readout, and off again. In readout mode, data-port reads return the code bytes instead of flash data. A read in this mode does not issue a flash read strobe.

Top module: `nhe_ecc_engine`

## Requirements
- R1: After reset, all accumulators and the readout position are zero, so the six bytes read in readout mode are all 0xFF.
- R2: The mode field is decoded as 00 = off, 01 = accumulate, 10 = readout and 11 = clear. In accumulate mode, every data-port transfer folds one byte into the current chunk. A transfer is a write (data taken from port_wdata_i) or a read (data taken from flash_rdata_i).
- R3: The code of a chunk is built from line parities and column parities, and all stored bits are inverted.
  - Line parities: for address bit k, line parity 2k is the XOR of the byte parities of all bytes whose chunk offset has bit k clear, and line parity 2k+1 covers the bytes where that bit is set.
  - Column parities: c0 covers bits 0,2,4,6; c1 covers 1,3,5,7; c2 covers 0,1,4,5; c3 covers 2,3,6,7; c4 covers 0..3; c5 covers 4..7. Each is taken over the XOR of all bytes of the chunk.
  - Byte 0 holds ~line[7:0] and byte 1 holds ~line[15:8].
  - Byte 2 holds {~c5,~c4,~c3,~c2,~c1,~c0} in bits 7:2, and bits 1:0 are 1.
- R4: After 256 accumulated bytes the engine moves to the next chunk. Once both chunk slots are full, further transfers change nothing.
- R5: In readout mode, successive data-port reads return chunk 0 byte 1, byte 0, byte 2, then chunk 1 byte 1, byte 0, byte 2. After the sixth read the sequence wraps to the start.
- R6: In readout mode, port_rdata_o carries the code byte and flash_rd_stb_o stays low. In every other mode, a read passes flash_rdata_i through and raises flash_rd_stb_o.
- R7: Clear mode zeroes all accumulators, the chunk byte count, the chunk slot and the readout position.
- R8: Off mode freezes the accumulators and the byte count without clearing them, so a later accumulate phase continues the same chunk.
- R9: When a read and a write fall in the same cycle, only the write counts: its byte is accumulated, no flash read strobe is raised, and the readout position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | ECC mode field (00 off, 01 accumulate, 10 readout, 11 clear) |
| port_wr_i | input | 1 | Data-port write this cycle |
| port_rd_i | input | 1 | Data-port read this cycle |
| port_wdata_i | input | 8 | Byte written through the data port |
| flash_rdata_i | input | 8 | Byte returned by the flash for a read |
| port_rdata_o | output | 8 | Data-port read result |
| flash_rd_stb_o | output | 1 | Flash read strobe request |

## Verification
A data-port write and a data-port read can arrive in the same cycle. The conflict matters in accumulate mode, where either could supply the folded byte, and in readout mode, where the read would step the code pointer. The random phase asserts both strobes together on about one transfer in eight, with different bytes on the write and flash buses. The bench then checks that no read strobe appears, that the later code bytes reflect only the written byte, and that the readout sequence does not skip a position.

// File: rtl/nhe_pkg.sv
package nhe_pkg;
    typedef enum logic [1:0] {
        ECC_OFF   = 2'b00,
        ECC_ACCUM = 2'b01,
        ECC_READ  = 2'b10,
        ECC_CLEAR = 2'b11
    } ecc_mode_e;

    localparam int unsigned CODE_BITS = 24;
endpackage

// File: rtl/nhe_byte_fold.sv
// Folds one byte into a chunk's line and column parity accumulators.
module nhe_byte_fold #(
    parameter int unsigned AW = 8
) (
    input  logic [7:0]      byte_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [2*AW-1:0] lp_i,
    input  logic [7:0]      col_i,
    output logic [2*AW-1:0] lp_o,
    output logic [7:0]      col_o
);
    logic par;
    assign par   = ^byte_i;
    assign col_o = col_i ^ byte_i;

    for (genvar k = 0; k < AW; k++) begin : g_line
        assign lp_o[2*k]   = lp_i[2*k]   ^ (par & ~addr_i[k]);
        assign lp_o[2*k+1] = lp_i[2*k+1] ^ (par &  addr_i[k]);
    end
endmodule

// File: rtl/nhe_code_pack.sv
// Turns a chunk's accumulators into the three inverted code bytes.
module nhe_code_pack #(
    parameter int unsigned AW = 8
) (
    input  logic [2*AW-1:0] lp_i,
    input  logic [7:0]      col_i,
    output logic [23:0]     code_o
);
    logic [15:0] lp_ext;
    logic [5:0]  cp;

    assign lp_ext = 16'(lp_i);
    assign cp[0] = col_i[6] ^ col_i[4] ^ col_i[2] ^ col_i[0];
    assign cp[1] = col_i[7] ^ col_i[5] ^ col_i[3] ^ col_i[1];
    assign cp[2] = col_i[5] ^ col_i[4] ^ col_i[1] ^ col_i[0];
    assign cp[3] = col_i[7] ^ col_i[6] ^ col_i[3] ^ col_i[2];
    assign cp[4] = ^col_i[3:0];
    assign cp[5] = ^col_i[7:4];

    assign code_o = {~cp, 2'b11, ~lp_ext[15:8], ~lp_ext[7:0]};
endmodule

// File: rtl/nhe_readout_seq.sv
// Steps through the code bytes in the order byte1, byte0, byte2 per chunk.
module nhe_readout_seq #(
    parameter int unsigned NUM_CHUNKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic                       step_i,
    input  logic [NUM_CHUNKS*24-1:0]   codes_i,
    output logic [7:0]                 byte_o
);
    localparam int unsigned CW = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;

    typedef struct packed {
        logic [CW-1:0] chunk;
        logic [1:0]    pos;
    } ro_state_t;

    ro_state_t st_d, st_q;
    logic [23:0] cur_code;

    always_comb begin
        cur_code = '0;
        for (int c = 0; c < NUM_CHUNKS; c++) begin
            if (st_q.chunk == CW'(c)) cur_code = codes_i[c*24 +: 24];
        end
        unique case (st_q.pos)
            2'd0:    byte_o = cur_code[15:8];
            2'd1:    byte_o = cur_code[7:0];
            default: byte_o = cur_code[23:16];
        endcase

        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (step_i) begin
            if (st_q.pos == 2'd2) begin
                st_d.pos   = 2'd0;
                st_d.chunk = (st_q.chunk == CW'(NUM_CHUNKS - 1)) ? '0 : st_q.chunk + CW'(1);
            end else begin
                st_d.pos = st_q.pos + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nhe_ecc_engine.sv
module nhe_ecc_engine #(
    parameter int unsigned CHUNK_BYTES = 256,
    parameter int unsigned NUM_CHUNKS  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       port_wr_i,
    input  logic       port_rd_i,
    input  logic [7:0] port_wdata_i,
    input  logic [7:0] flash_rdata_i,
    output logic [7:0] port_rdata_o,
    output logic       flash_rd_stb_o
);
    import nhe_pkg::*;

    localparam int unsigned AW  = $clog2(CHUNK_BYTES);
    localparam int unsigned CW  = $clog2(NUM_CHUNKS + 1);
    localparam int unsigned LPW = 2 * AW;

    typedef struct packed {
        logic [AW-1:0]                    addr;
        logic [CW-1:0]                    slot;
        logic [NUM_CHUNKS-1:0][LPW-1:0]   lp;
        logic [NUM_CHUNKS-1:0][7:0]       col;
    } acc_state_t;

    acc_state_t st_d, st_q;
    ecc_mode_e  mode;
    logic       xfer;
    logic [7:0] xbyte;
    logic       ro_step;
    logic [7:0] ro_byte;

    logic [NUM_CHUNKS-1:0][LPW-1:0] fold_lp;
    logic [NUM_CHUNKS-1:0][7:0]     fold_col;
    logic [NUM_CHUNKS*24-1:0]       codes;

    assign mode    = ecc_mode_e'(mode_i);
    assign xfer    = port_wr_i | port_rd_i;
    assign xbyte   = port_wr_i ? port_wdata_i : flash_rdata_i;
    assign ro_step = (mode == ECC_READ) && port_rd_i && !port_wr_i;

    for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
        nhe_byte_fold #(.AW(AW)) u_fold (
            .byte_i (xbyte),
            .addr_i (st_q.addr),
            .lp_i   (st_q.lp[g]),
            .col_i  (st_q.col[g]),
            .lp_o   (fold_lp[g]),
            .col_o  (fold_col[g])
        );
        nhe_code_pack #(.AW(AW)) u_pack (
            .lp_i   (st_q.lp[g]),
            .col_i  (st_q.col[g]),
            .code_o (codes[g*24 +: 24])
        );
    end

    nhe_readout_seq #(.NUM_CHUNKS(NUM_CHUNKS)) u_ro (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (mode == ECC_CLEAR),
        .step_i  (ro_step),
        .codes_i (codes),
        .byte_o  (ro_byte)
    );

    always_comb begin
        st_d = st_q;
        unique case (mode)
            ECC_CLEAR: st_d = '0;
            ECC_ACCUM: begin
                if (xfer && (st_q.slot < CW'(NUM_CHUNKS))) begin
                    for (int c = 0; c < NUM_CHUNKS; c++) begin
                        if (st_q.slot == CW'(c)) begin
                            st_d.lp[c]  = fold_lp[c];
                            st_d.col[c] = fold_col[c];
                        end
                    end
                    if (st_q.addr == AW'(CHUNK_BYTES - 1)) begin
                        st_d.addr = '0;
                        st_d.slot = st_q.slot + CW'(1);
                    end else begin
                        st_d.addr = st_q.addr + AW'(1);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign port_rdata_o   = (mode == ECC_READ) ? ro_byte : flash_rdata_i;
    assign flash_rd_stb_o = port_rd_i && !port_wr_i && (mode != ECC_READ);
endmodule

// File: rtl/nhe_ecc_engine_chk.sv
module nhe_ecc_engine_chk #(
    parameter int unsigned NUM_CHUNKS = 2,
    parameter int unsigned AW         = 8,
    parameter int unsigned CW         = 2,
    parameter int unsigned LPW        = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  mode_i,
    input logic                        port_rd_i,
    input logic                        port_wr_i,
    input logic                        flash_rd_stb_o,
    input logic [AW-1:0]               addr_q,
    input logic [CW-1:0]               slot_q,
    input logic [NUM_CHUNKS*LPW-1:0]   lp_q,
    input logic [NUM_CHUNKS*8-1:0]     col_q
);
    p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd_i && !port_wr_i && mode_i != 2'b10) |-> flash_rd_stb_o);

    p_no_strobe_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |-> !flash_rd_stb_o);

    p_dual_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd_i && port_wr_i) |-> !flash_rd_stb_o);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |=> (slot_q == '0 && addr_q == '0 && lp_q == '0 && col_q == '0));

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |=> ($stable(lp_q) && $stable(col_q) && $stable(addr_q) && $stable(slot_q)));

    p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= CW'(NUM_CHUNKS));

    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == CW'(NUM_CHUNKS) && mode_i != 2'b11) |=> ($stable(lp_q) && $stable(col_q) && $stable(slot_q)));

    p_accum_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && (port_rd_i || port_wr_i) && slot_q < CW'(NUM_CHUNKS))
        |=> (addr_q == $past(addr_q) + AW'(1)));
endmodule

bind nhe_ecc_engine nhe_ecc_engine_chk #(
    .NUM_CHUNKS (NUM_CHUNKS),
    .AW         (AW),
    .CW         (CW),
    .LPW        (LPW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode_i),
    .port_rd_i      (port_rd_i),
    .port_wr_i      (port_wr_i),
    .flash_rd_stb_o (flash_rd_stb_o),
    .addr_q         (st_q.addr),
    .slot_q         (st_q.slot),
    .lp_q           (st_q.lp),
    .col_q          (st_q.col)
);

// File: tb/nhe_ecc_engine_test.sv
module nhe_ecc_engine_test;
    localparam logic [1:0] M_OFF = 2'b00, M_ACC = 2'b01, M_RD = 2'b10, M_CLR = 2'b11;
    localparam int TOTAL = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = M_OFF;
    logic       port_wr_i = 1'b0, port_rd_i = 1'b0;
    logic [7:0] port_wdata_i = '0, flash_rdata_i = '0;
    logic [7:0] port_rdata_o;
    logic       flash_rd_stb_o;

    int n_tests = 0, n_fail = 0;
    logic [7:0] mdl [0:1][0:255];
    int mcnt = 0;
    int rp = 0;

    always #5 clk = ~clk;

    nhe_ecc_engine uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .port_wr_i(port_wr_i), .port_rd_i(port_rd_i),
        .port_wdata_i(port_wdata_i), .flash_rdata_i(flash_rdata_i),
        .port_rdata_o(port_rdata_o), .flash_rd_stb_o(flash_rd_stb_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_code(input int c);
        logic [15:0] lp = '0;
        logic [7:0]  col = '0;
        logic [5:0]  cp;
        int n = mcnt - 256 * c;
        if (n < 0) n = 0;
        if (n > 256) n = 256;
        for (int i = 0; i < n; i++) begin
            col ^= mdl[c][i];
            if (^mdl[c][i]) begin
                for (int k = 0; k < 8; k++) begin
                    if ((i >> k) & 1) lp[2*k+1] ^= 1'b1;
                    else              lp[2*k]   ^= 1'b1;
                end
            end
        end
        cp[0] = col[0] ^ col[2] ^ col[4] ^ col[6];
        cp[1] = col[1] ^ col[3] ^ col[5] ^ col[7];
        cp[2] = col[0] ^ col[1] ^ col[4] ^ col[5];
        cp[3] = col[2] ^ col[3] ^ col[6] ^ col[7];
        cp[4] = ^col[3:0];
        cp[5] = ^col[7:4];
        return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
    endfunction

    function automatic logic [7:0] exp_byte(input int k);
        logic [23:0] code = ref_code(k / 3);
        case (k % 3)
            0:       return code[15:8];
            1:       return code[7:0];
            default: return code[23:16];
        endcase
    endfunction

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_i = m;
        if (m == M_CLR) begin mcnt = 0; rp = 0; end
    endtask

    // One data-port cycle; checks strobe, passthrough and readout order.
    task automatic xfer(input bit wr, input bit rd, input logic [7:0] d);
        @(negedge clk);
        port_wr_i = wr; port_rd_i = rd; port_wdata_i = d;
        flash_rdata_i = wr ? 8'($urandom) : d;
        #1;
        if (wr && rd) chk("R9 strobe", flash_rd_stb_o, 1'b0);
        else chk("R6 strobe", flash_rd_stb_o, rd && !wr && mode_i != M_RD);
        if (rd && !wr && mode_i != M_RD) chk("R6 passthrough", port_rdata_o, flash_rdata_i);
        if (rd && !wr && mode_i == M_RD) begin
            chk($sformatf("R5 readout pos %0d", rp), port_rdata_o, exp_byte(rp));
            rp = (rp + 1) % 6;
        end
        @(posedge clk); #1;
        port_wr_i = 1'b0; port_rd_i = 1'b0;
        if (mode_i == M_ACC && (wr || rd) && mcnt < TOTAL) begin
            mdl[mcnt / 256][mcnt % 256] = d;
            mcnt++;
        end
    endtask

    task automatic rnd_xfers(input int n);
        for (int i = 0; i < n; i++) begin
            int r = $urandom % 8;
            xfer(r < 4, r >= 3, 8'($urandom));
        end
    endtask

    task automatic read_all(input int n);
        for (int i = 0; i < n; i++) xfer(1'b0, 1'b1, 8'($urandom));
    endtask

    task automatic enable_seq;
        set_mode(M_CLR); set_mode(M_OFF); set_mode(M_ACC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state reads all 0xFF; R6 passthrough in off mode
        xfer(1'b0, 1'b1, 8'h3c);
        set_mode(M_RD);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); port_rd_i = 1'b1; flash_rdata_i = 8'h00; #1;
            chk("R1 reset code byte", port_rdata_o, 8'hff);
            @(posedge clk); #1; port_rd_i = 1'b0;
        end
        rp = 0;

        // R3 directed: single byte 0x01 at offset 0 gives AA AA AB
        enable_seq();
        xfer(1'b1, 1'b0, 8'h01);
        set_mode(M_OFF); set_mode(M_RD);
        @(negedge clk); port_rd_i = 1'b1; #1; chk("R3 byte1", port_rdata_o, 8'haa);
        @(posedge clk); #1; port_rd_i = 1'b0;
        @(negedge clk); port_rd_i = 1'b1; #1; chk("R3 byte0", port_rdata_o, 8'haa);
        @(posedge clk); #1; port_rd_i = 1'b0;
        @(negedge clk); port_rd_i = 1'b1; #1; chk("R3 byte2", port_rdata_o, 8'hab);
        @(posedge clk); #1; port_rd_i = 1'b0;
        rp = 3;
        read_all(4); // chunk 1 empty then wrap to chunk 0 (R5)
        set_mode(M_OFF);

        // R2/R4/R9: full random page, then extra bytes that must be ignored
        enable_seq();
        rnd_xfers(TOTAL);
        rnd_xfers(20);
        set_mode(M_OFF); set_mode(M_RD);
        read_all(7);
        // R9 in readout: dual access must not advance pointer
        xfer(1'b1, 1'b1, 8'h5a);
        read_all(5);

        // R8: off mode transfers leave the code untouched
        set_mode(M_OFF);
        rnd_xfers(30);
        set_mode(M_RD);
        read_all(6);

        // R8: partial chunk, freeze, resume across chunk boundary
        enable_seq();
        rnd_xfers(250);
        set_mode(M_OFF);
        rnd_xfers(10);
        set_mode(M_ACC);
        rnd_xfers(12);
        set_mode(M_OFF); set_mode(M_RD);
        read_all(6);

        // R7: clear mid-readout resets code and readout position
        read_all(2);
        set_mode(M_CLR); set_mode(M_OFF); set_mode(M_RD);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); port_rd_i = 1'b1; #1;
            chk("R7 cleared code byte", port_rdata_o, 8'hff);
            @(posedge clk); #1; port_rd_i = 1'b0;
        end
        rp = 0;

        // R7: clear after data, first read is chunk 0 byte 1
        enable_seq();
        xfer(1'b1, 1'b0, 8'h80);
        xfer(1'b1, 1'b0, 8'h07);
        set_mode(M_OFF); set_mode(M_RD);
        read_all(3);
        set_mode(M_OFF);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule